// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a synchronous register stage for the command and address path of a memory module. On each rising clock edge it captures a 25-bit input word and presents it on registered outputs. Two static configuration inputs select the operating mode. In one-to-one mode all 25 bits are registered independently. In fan-out mode only the low 14 bits are registered, and each one drives two identical output copies, named A and B.

Three positions of the word carry control signals. These are clock-enable, on-die termination and the module chip-select. The chip-select position is fixed, while the configuration picks the positions of the other two. When the chip-select bit and a second chip-select input are both high, the ordinary data outputs are frozen to save switching power. The three control bits keep loading on every edge. An asynchronous active-low reset clears every output at once and takes priority over the freeze.

Top module: `cfg_buf_reg`

## Requirements
- R1: With `cfg_fanout` low, every `qa[i]` (i = 0..24) takes `din[i]` at each unfrozen rising edge, and `qb` stays all zero.
- R2: With `cfg_fanout` high, at each unfrozen edge `qa[13:0]` and `qb[13:0]` both take `din[13:0]`. `qa[24:14]` stays zero, and `din[24:14]` has no effect on any output.
- R3: At an edge where `din[6]` and `cs_aux` are both high, every non-control bit of `qa` and `qb` keeps its previous value.
- R4: At an edge where `din[6]` or `cs_aux` is low, all active output bits load the new input data.
- R5: In one-to-one mode, and in fan-out mode with `cfg_layout_b` low, bit 0 (clock-enable) and bit 3 (termination) load `din` at every edge, even while frozen. In one-to-one mode `cfg_layout_b` has no effect.
- R6: In fan-out mode with `cfg_layout_b` high, bit 13 (clock-enable) and bit 10 (termination) load at every edge, even while frozen. Bits 0 and 3 are then ordinary bits that freeze.
- R7: Bit 6 (chip-select) loads `din[6]` at every edge in every mode, so its output shows the value that froze the other bits.
- R8: A low `rst_n` forces `qa` and `qb` to zero immediately, without waiting for a clock edge, including when it falls in the middle of a cycle.
- R9: Reset overrides the freeze and any input. After `rst_n` is released, the outputs stay zero until the first rising edge, which loads `din` normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge capture clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| cfg_fanout | input | 1 | Static mode: 0 one-to-one 25 bits, 1 fan-out 14 bits |
| cfg_layout_b | input | 1 | Static control-bit layout in fan-out mode: 0 layout A, 1 layout B |
| din | input | 25 | Input word; bit 6 is the module chip-select |
| cs_aux | input | 1 | Second chip-select; with din[6] high, freezes ordinary bits |
| qa | output | 25 | Registered outputs (A copies in fan-out mode) |
| qb | output | 14 | B copies in fan-out mode, zero in one-to-one mode |

## Verification
A wrong hold decision shows up on the first edge after the input word changes. A frozen bit then carries new data, or a loading bit keeps stale data, on `qa` and `qb` one clock after the stimulus. A control position mapped to the wrong bit is exposed by a frozen edge in each layout: exactly one bit differs from expectation. A missing asynchronous path or an unmasked inactive bit shows within the same cycle, as a nonzero output while reset is low or as a nonzero upper or B output in the wrong mode.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;
    localparam int WIDE_W     = 25;
    localparam int NARROW_W   = 14;
    localparam int CS_POS     = 6;
    localparam int CKE_POS_A  = 0;
    localparam int ODT_POS_A  = 3;
    localparam int CKE_POS_B  = 13;
    localparam int ODT_POS_B  = 10;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_FAN_A  = 2'd1,
        MODE_FAN_B  = 2'd2
    } rbuf_mode_e;
endpackage

// File: rtl/rbuf_mode_map.sv
module rbuf_mode_map
    import rbuf_pkg::*;
#(
    parameter int W      = WIDE_W,
    parameter int N      = NARROW_W,
    parameter int CS_P   = CS_POS,
    parameter int CKE_A  = CKE_POS_A,
    parameter int ODT_A  = ODT_POS_A,
    parameter int CKE_B  = CKE_POS_B,
    parameter int ODT_B  = ODT_POS_B
) (
    input  logic         cfg_fanout,
    input  logic         cfg_layout_b,
    output rbuf_mode_e   mode,
    output logic [W-1:0] act_mask,
    output logic [W-1:0] exempt_mask
);
    localparam logic [W-1:0] NARROW_MASK = {{(W-N){1'b0}}, {N{1'b1}}};

    always_comb begin
        if (!cfg_fanout)        mode = MODE_DIRECT;
        else if (!cfg_layout_b) mode = MODE_FAN_A;
        else                    mode = MODE_FAN_B;
    end

    always_comb begin
        act_mask    = (mode == MODE_DIRECT) ? {W{1'b1}} : NARROW_MASK;
        exempt_mask = '0;
        exempt_mask[CS_P] = 1'b1;
        if (mode == MODE_FAN_B) begin
            exempt_mask[CKE_B] = 1'b1;
            exempt_mask[ODT_B] = 1'b1;
        end else begin
            exempt_mask[CKE_A] = 1'b1;
            exempt_mask[ODT_A] = 1'b1;
        end
    end

    // R7
    always_comb begin
        cs_exempt_chk: assert (exempt_mask[CS_P] && act_mask[CS_P]);
    end
endmodule

// File: rtl/rbuf_bit_bank.sv
module rbuf_bit_bank #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         dcs,
    input  logic         cs_aux,
    input  logic [W-1:0] act_mask,
    input  logic [W-1:0] exempt_mask,
    output logic [W-1:0] core_q
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;
    logic  freeze;

    assign freeze = dcs & cs_aux;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < W; i++) begin
            if (!act_mask[i])
                bank_d.bits[i] = 1'b0;
            else if (freeze && !exempt_mask[i])
                bank_d.bits[i] = bank_q.bits[i];
            else
                bank_d.bits[i] = din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign core_q = bank_q.bits;

    // R3
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dcs && cs_aux) |=> ((core_q & ~$past(exempt_mask)) ==
                             ($past(core_q) & ~$past(exempt_mask))));

    // R4
    load_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dcs && cs_aux) |=> (core_q == ($past(din) & $past(act_mask))));

    // R5
    exempt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((core_q & $past(exempt_mask)) == ($past(din) & $past(exempt_mask))));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q & ~act_mask) == '0);
endmodule

// File: rtl/rbuf_fanout_stage.sv
module rbuf_fanout_stage #(
    parameter int W = 25,
    parameter int N = 14
) (
    input  logic         cfg_fanout,
    input  logic [W-1:0] core_q,
    output logic [W-1:0] qa,
    output logic [N-1:0] qb
);
    assign qa = core_q;

    for (genvar g = 0; g < N; g++) begin : g_copy
        assign qb[g] = cfg_fanout & core_q[g];
    end
endmodule

// File: rtl/cfg_buf_reg.sv
module cfg_buf_reg
    import rbuf_pkg::*;
#(
    parameter int W     = WIDE_W,
    parameter int N     = NARROW_W,
    parameter int CS_P  = CS_POS,
    parameter int CKE_A = CKE_POS_A,
    parameter int ODT_A = ODT_POS_A,
    parameter int CKE_B = CKE_POS_B,
    parameter int ODT_B = ODT_POS_B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_fanout,
    input  logic         cfg_layout_b,
    input  logic [W-1:0] din,
    input  logic         cs_aux,
    output logic [W-1:0] qa,
    output logic [N-1:0] qb
);
    rbuf_mode_e   mode;
    logic [W-1:0] act_mask;
    logic [W-1:0] exempt_mask;
    logic [W-1:0] core_q;

    rbuf_mode_map #(
        .W(W), .N(N), .CS_P(CS_P),
        .CKE_A(CKE_A), .ODT_A(ODT_A), .CKE_B(CKE_B), .ODT_B(ODT_B)
    ) u_map (
        .cfg_fanout   (cfg_fanout),
        .cfg_layout_b (cfg_layout_b),
        .mode         (mode),
        .act_mask     (act_mask),
        .exempt_mask  (exempt_mask)
    );

    rbuf_bit_bank #(.W(W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .dcs         (din[CS_P]),
        .cs_aux      (cs_aux),
        .act_mask    (act_mask),
        .exempt_mask (exempt_mask),
        .core_q      (core_q)
    );

    rbuf_fanout_stage #(.W(W), .N(N)) u_fan (
        .cfg_fanout (cfg_fanout),
        .core_q     (core_q),
        .qa         (qa),
        .qb         (qb)
    );

    // R2
    fan_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_DIRECT) |-> (qb == qa[N-1:0] && qa[W-1:N] == '0));

    // R1
    direct_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIRECT) |-> (qb == '0));

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (qa == '0 && qb == '0));
endmodule

// File: tb/cfg_buf_reg_test.sv
module cfg_buf_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fanout = 1'b0;
    logic        cfg_layout_b = 1'b0;
    logic [24:0] din = '0;
    logic        cs_aux = 1'b0;
    logic [24:0] qa;
    logic [13:0] qb;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [24:0] exp_st = '0;

    always #4 clk = ~clk;

    cfg_buf_reg uut (
        .clk(clk), .rst_n(rst_n), .cfg_fanout(cfg_fanout),
        .cfg_layout_b(cfg_layout_b), .din(din), .cs_aux(cs_aux),
        .qa(qa), .qb(qb)
    );

    // Expected next state derived from the requirements
    function automatic logic [24:0] next_exp(logic [24:0] prev, logic [24:0] d,
                                             logic c2, logic fan, logic lb);
        logic [24:0] ctl;
        logic [24:0] act;
        logic [24:0] r;
        act = fan ? 25'h0003FFF : 25'h1FFFFFF;
        ctl = 25'h0000040;                                          // R7 bit 6
        if (fan && lb) ctl = ctl | (25'h1 << 13) | (25'h1 << 10);    // R6
        else           ctl = ctl | 25'h1 | (25'h1 << 3);             // R5
        if (d[6] && c2) r = (prev & ~ctl) | (d & ctl);               // R3
        else            r = d;                                       // R4
        return r & act;                                              // R1 R2
    endfunction

    task automatic check(string tag, logic [24:0] act, logic [24:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag);
        logic [24:0] eqa;
        logic [24:0] eqb;
        eqa = cfg_fanout ? (exp_st & 25'h0003FFF) : exp_st;
        eqb = cfg_fanout ? (exp_st & 25'h0003FFF) : 25'h0;
        check({tag, " qa"}, qa, eqa);
        check({tag, " qb"}, {11'b0, qb}, eqb);
    endtask

    task automatic step(logic [24:0] d, logic c2, string tag);
        @(negedge clk);
        din = d;
        cs_aux = c2;
        @(posedge clk);
        exp_st = next_exp(exp_st, d, c2, cfg_fanout, cfg_layout_b);
        #2;
        check_out(tag);
    endtask

    task automatic do_reset(logic fan, logic lb);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_fanout = fan;
        cfg_layout_b = lb;
        din = '0;
        cs_aux = 1'b0;
        exp_st = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state;
        #1;
        check("R8 reset state qa", qa, 25'h0);
        check("R8 reset state qb", {11'b0, qb}, 25'h0);
    endtask

    task automatic t_direct;
        do_reset(1'b0, 1'b0);
        step(25'h1FFFFFF, 1'b0, "R1 all ones");
        step(25'h0A5A5A5, 1'b0, "R1 pattern a");
        step(25'h1234567, 1'b0, "R1 pattern b");
        step(25'h0000000, 1'b1, "R1 zeros");
        cfg_layout_b = 1'b1;
        step(25'h1F0F0BF, 1'b0, "R5 layout ignored in direct");
    endtask

    task automatic t_fan_a;
        do_reset(1'b1, 1'b0);
        step(25'h1FFC000, 1'b0, "R2 upper ignored");
        step(25'h0002A95, 1'b0, "R2 copies pattern");
        step(25'h1FFFFFF, 1'b0, "R2 all ones");
    endtask

    task automatic t_gate_direct;
        do_reset(1'b0, 1'b0);
        step(25'h0AAAAAA, 1'b1, "R4 dcs low loads");
        step(25'h1555555, 1'b1, "R3 R5 R7 frozen keeps data");
        step(25'h000004F, 1'b1, "R3 R5 frozen control bits");
        step(25'h1F0F0B0, 1'b1, "R4 dcs low after freeze");
        step(25'h0FFFFC3, 1'b0, "R4 cs_aux low loads");
    endtask

    task automatic t_gate_fan;
        do_reset(1'b1, 1'b0);
        step(25'h0001234, 1'b0, "R2 fan A load");
        step(25'h0003FFF, 1'b1, "R5 fan A frozen");
        do_reset(1'b1, 1'b1);
        step(25'h0000000, 1'b0, "R6 fan B clear");
        step(25'h0003FFF, 1'b1, "R6 R7 fan B frozen");
        step(25'h0000049, 1'b1, "R6 bits 0 3 freeze in B");
        step(25'h0000000, 1'b1, "R4 fan B open");
    endtask

    task automatic t_reset_mid;
        do_reset(1'b0, 1'b0);
        step(25'h1FFFFFF, 1'b0, "R8 preload");
        @(posedge clk);
        exp_st = next_exp(exp_st, din, cs_aux, cfg_fanout, cfg_layout_b);
        #3;
        rst_n = 1'b0;
        #1;
        check("R8 mid-cycle clear qa", qa, 25'h0);
        check("R8 mid-cycle clear qb", {11'b0, qb}, 25'h0);
        @(negedge clk);
        din = 25'h1FFFFFF;
        cs_aux = 1'b1;
        @(posedge clk);
        #2;
        check("R9 reset over freeze qa", qa, 25'h0);
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        exp_st = '0;
        #1;
        check("R9 low after release qa", qa, 25'h0);
        @(posedge clk);
        exp_st = next_exp(exp_st, din, cs_aux, cfg_fanout, cfg_layout_b);
        #2;
        check_out("R9 first edge loads");
    endtask

    initial begin
        t_reset_state();
        t_direct();
        t_fan_a();
        t_gate_direct();
        t_gate_fan();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule